// File: doc/BRIEF.md
# Constant-fraction arrival time extractor

This block takes the digitized samples of one captured pulse and returns the time at which the pulse's leading edge crossed a fixed fraction of its own height. The time is reported as a sample index plus an 8-bit binary fraction of a sample period. The threshold is set from the measured peak rather than from an absolute level, so pulses of different heights that share a shape give the same timestamp. Between samples, the crossing point is found by straight-line interpolation.

Samples enter on a valid/ready stream. A sample moves when `in_valid` and `in_ready` are both high on a rising clock edge. `in_first` marks the first sample of a window and `in_last` marks the final one. The block subtracts a pedestal from each sample and stores it in a local buffer. It tracks the peak while the window arrives. After the final sample it holds `in_ready` low and works out the result in four steps:
- It computes the threshold.
- It scans backward from the peak for the nearest sample below the threshold.
- It runs a shift-and-subtract divider to get the fraction.
- It presents the result on a valid/ready output.

The result stays on the output, unchanged, until the consumer takes it. Only then does `in_ready` rise again. A stalled consumer therefore stalls the producer, and no sample is lost or reordered. `frac_sel` and `pedestal` must stay constant from the first sample of a window until its result has been taken.

Top module: `cfd_timer`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Each accepted sample is stored as `in_data - pedestal`, with both read as signed values. The peak is the largest stored value. On a tie the earliest sample holds the peak.
- R3: The threshold is floor(peak × `frac_sel` / 256), where `frac_sel` is unsigned. 128 means one half and 0 gives a threshold of zero.
- R4: The search starts at the sample just before the peak and moves toward index 0. It stops at the first sample k whose value is strictly below the threshold. Samples k and k+1 form the interpolation pair.
- R5: The quotient q = floor(256 × (thr − s[k]) / (s[k+1] − s[k])) lies between 0 and 256. The result is `out_index` = k + (q / 256) and `out_frac` = q mod 256. So when s[k+1] equals the threshold exactly, the result is index k+1 with fraction 0.
- R6: `out_error` is 1, with `out_index` and `out_frac` both 0, in any of three cases:
  - the peak is at index 0;
  - no sample before the peak lies below the threshold;
  - the peak is not greater than 0.
- R7: Exactly one result is produced per window. While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_index`, `out_frac` and `out_error` keep their values.
- R8: `in_ready` is 0 from the cycle after the last sample is accepted until the cycle after the result is taken. `in_valid` has no effect during that time.
- R9: Samples beyond the buffer depth (64) in a window are dropped. They do not change the peak or the result, and the window still ends on `in_last`.
- R10: A sample with `in_first` set restarts the window at index 0 and discards samples already received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block can accept a sample |
| in_data | input | 12 | Signed sample value |
| in_first | input | 1 | Sample is the first of a window |
| in_last | input | 1 | Sample is the last of a window |
| frac_sel | input | 8 | Threshold fraction in 1/256 of the peak |
| pedestal | input | 12 | Signed offset subtracted from each sample |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_index | output | 6 | Integer sample index of the crossing |
| out_frac | output | 8 | Fraction of a sample period after `out_index` |
| out_error | output | 1 | No valid crossing found |

## Verification
The hardest case is a held result meeting a producer that already has the next window's sample on the input in the same cycle. The bench provokes this by holding `out_ready` low for several cycles while driving `in_valid` high with a large, extreme sample flagged as last. In each of those cycles it checks that the result fields stay put and that `in_ready` stays low. After releasing the result, it sends a normal window and compares the timestamp with the hand-computed value; any leak of the stray sample into the buffer, peak or result would show up as a mismatch there.

// File: rtl/cfd_pkg.sv
package cfd_pkg;
  typedef enum logic [2:0] {
    ST_LOAD,
    ST_THR,
    ST_SCAN,
    ST_DIV,
    ST_OUT
  } cfd_state_e;
endpackage

// File: rtl/cfd_capture.sv
module cfd_capture #(
  parameter int W     = 12,
  parameter int DEPTH = 64,
  parameter int VW    = W + 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 wr_first,
  input  logic                 wr_last,
  input  logic [W-1:0]         wr_data,
  input  logic [W-1:0]         pedestal,
  input  logic [AW-1:0]        rd_addr_a,
  input  logic [AW-1:0]        rd_addr_b,
  output logic signed [VW-1:0] rd_a,
  output logic signed [VW-1:0] rd_b,
  output logic signed [VW-1:0] peak_val,
  output logic [AW-1:0]        peak_idx
);
  logic signed [VW-1:0] mem [DEPTH];
  logic [AW:0]          cnt;
  logic [AW:0]          widx;
  logic signed [VW-1:0] value;
  logic                 in_range;

  assign widx     = wr_first ? '0 : cnt;
  assign in_range = widx < (AW+1)'(DEPTH);
  assign value    = VW'($signed(wr_data)) - VW'($signed(pedestal));
  assign rd_a     = mem[rd_addr_a];
  assign rd_b     = mem[rd_addr_b];

  always_ff @(posedge clk) begin
    if (wr_en && in_range) mem[widx[AW-1:0]] <= value;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      peak_val <= '0;
      peak_idx <= '0;
    end else if (wr_en) begin
      if (in_range) begin
        cnt <= wr_last ? '0 : widx + 1'b1;
        if (widx == '0 || value > peak_val) begin
          peak_val <= value;
          peak_idx <= widx[AW-1:0];
        end
      end else begin
        cnt <= wr_last ? '0 : cnt;
      end
    end
  end

  // R9
  overflow_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !in_range) |=> ($stable(peak_val) && $stable(peak_idx)));
endmodule

// File: rtl/cfd_search.sv
module cfd_search #(
  parameter int VW    = 14,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [AW-1:0]        peak_idx,
  input  logic signed [VW-1:0] thr,
  input  logic signed [VW-1:0] rd_a,
  input  logic signed [VW-1:0] rd_b,
  output logic [AW-1:0]        rd_addr_a,
  output logic [AW-1:0]        rd_addr_b,
  output logic                 found,
  output logic                 fail,
  output logic signed [VW-1:0] lo,
  output logic signed [VW-1:0] hi,
  output logic [AW-1:0]        k
);
  logic active;

  assign rd_addr_a = k;
  assign rd_addr_b = k + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      found  <= 1'b0;
      fail   <= 1'b0;
      k      <= '0;
      lo     <= '0;
      hi     <= '0;
    end else begin
      found <= 1'b0;
      fail  <= 1'b0;
      if (start) begin
        if (peak_idx == '0) begin
          fail <= 1'b1;
        end else begin
          k      <= peak_idx - 1'b1;
          active <= 1'b1;
        end
      end else if (active) begin
        if (rd_a < thr) begin
          found  <= 1'b1;
          lo     <= rd_a;
          hi     <= rd_b;
          active <= 1'b0;
        end else if (k == '0) begin
          fail   <= 1'b1;
          active <= 1'b0;
        end else begin
          k <= k - 1'b1;
        end
      end
    end
  end

  // R4
  pair_straddle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (lo < thr && hi >= thr));
  // R4
  found_fail_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(found && fail));
endmodule

// File: rtl/cfd_divider.sv
module cfd_divider #(
  parameter int NW  = 15,
  parameter int FW  = 8,
  localparam int QW = FW + 1,
  localparam int CW = $clog2(QW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [NW-1:0] den,
  output logic          done,
  output logic [QW-1:0] quo
);
  logic [NW:0]   rem;
  logic [CW-1:0] steps;
  logic          busy;
  logic          ge;

  assign ge = rem >= {1'b0, den};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem   <= '0;
      steps <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      quo   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem   <= {1'b0, num};
        quo   <= '0;
        steps <= CW'(QW);
        busy  <= 1'b1;
      end else if (busy) begin
        quo   <= {quo[QW-2:0], ge};
        rem   <= (ge ? rem - {1'b0, den} : rem) << 1;
        steps <= steps - 1'b1;
        if (steps == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R5
  operand_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (num <= den && den != '0));
  // R5
  quotient_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (quo <= QW'(1 << FW)));
endmodule

// File: rtl/cfd_timer.sv
module cfd_timer #(
  parameter int SAMPLE_W = 12,
  parameter int DEPTH    = 64,
  parameter int FRAC_W   = 8,
  localparam int AW      = $clog2(DEPTH),
  localparam int VW      = SAMPLE_W + 2,
  localparam int NW      = VW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                in_first,
  input  logic                in_last,
  input  logic [FRAC_W-1:0]   frac_sel,
  input  logic [SAMPLE_W-1:0] pedestal,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [AW-1:0]       out_index,
  output logic [FRAC_W-1:0]   out_frac,
  output logic                out_error
);
  import cfd_pkg::*;

  cfd_state_e state;
  logic accept;
  logic signed [VW-1:0] rd_a, rd_b, peak_val, lo, hi, thr;
  logic [AW-1:0] peak_idx, rd_addr_a, rd_addr_b, k;
  logic s_start, s_found, s_fail, d_done;
  logic signed [VW+FRAC_W:0] prod;
  logic signed [NW-1:0] num_s, den_s;
  logic [FRAC_W:0] quo;

  assign accept    = in_valid && in_ready;
  assign in_ready  = (state == ST_LOAD);
  assign out_valid = (state == ST_OUT);
  assign s_start   = (state == ST_THR) && (peak_val > 0);
  assign prod      = peak_val * $signed({1'b0, frac_sel});
  assign num_s     = NW'(thr) - NW'(lo);
  assign den_s     = NW'(hi) - NW'(lo);

  cfd_capture #(.W(SAMPLE_W), .DEPTH(DEPTH), .VW(VW)) u_cap (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_first(in_first),
    .wr_last(in_last), .wr_data(in_data), .pedestal(pedestal),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .rd_a(rd_a), .rd_b(rd_b),
    .peak_val(peak_val), .peak_idx(peak_idx)
  );

  cfd_search #(.VW(VW), .DEPTH(DEPTH)) u_search (
    .clk(clk), .rst_n(rst_n), .start(s_start), .peak_idx(peak_idx),
    .thr(thr), .rd_a(rd_a), .rd_b(rd_b), .rd_addr_a(rd_addr_a),
    .rd_addr_b(rd_addr_b), .found(s_found), .fail(s_fail),
    .lo(lo), .hi(hi), .k(k)
  );

  cfd_divider #(.NW(NW), .FW(FRAC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(s_found), .num(num_s), .den(den_s),
    .done(d_done), .quo(quo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_LOAD;
      thr       <= '0;
      out_index <= '0;
      out_frac  <= '0;
      out_error <= 1'b0;
    end else begin
      case (state)
        ST_LOAD: if (accept && in_last) state <= ST_THR;
        ST_THR: begin
          thr <= prod[VW+FRAC_W-1:FRAC_W];
          if (peak_val > 0) begin
            state <= ST_SCAN;
          end else begin
            out_index <= '0;
            out_frac  <= '0;
            out_error <= 1'b1;
            state     <= ST_OUT;
          end
        end
        ST_SCAN: begin
          if (s_found) begin
            state <= ST_DIV;
          end else if (s_fail) begin
            out_index <= '0;
            out_frac  <= '0;
            out_error <= 1'b1;
            state     <= ST_OUT;
          end
        end
        ST_DIV: if (d_done) begin
          out_index <= k + AW'(quo[FRAC_W]);
          out_frac  <= quo[FRAC_W-1:0];
          out_error <= 1'b0;
          state     <= ST_OUT;
        end
        ST_OUT: if (out_ready) state <= ST_LOAD;
        default: state <= ST_LOAD;
      endcase
    end
  end

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_index) &&
                                   $stable(out_frac) && $stable(out_error)));
  // R8
  no_intake_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  // R6
  error_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_error) |-> (out_index == '0 && out_frac == '0));
  // R8
  last_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_last) |=> !in_ready);
endmodule

// File: tb/cfd_timer_tb.sv
module cfd_timer_tb;
  typedef struct packed {
    logic [0:7][15:0] s;
    logic [7:0]       frac;
    logic [15:0]      ped;
    logic [5:0]       idx;
    logic [7:0]       fr;
    logic             err;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    // R4 R5: s[k+1] equals threshold exactly -> index k+1, fraction 0
    '{{16'd0, 16'd0, 16'd10, 16'd50, 16'd100, 16'd80, 16'd40, 16'd10}, 8'd128, 16'd0, 6'd3, 8'd0, 1'b0},
    // R3 R5: half threshold
    '{{16'd0, 16'd20, 16'd60, 16'd120, 16'd200, 16'd150, 16'd100, 16'd50}, 8'd128, 16'd0, 6'd2, 8'd170, 1'b0},
    // R3: quarter threshold
    '{{16'd0, 16'd20, 16'd60, 16'd120, 16'd200, 16'd150, 16'd100, 16'd50}, 8'd64, 16'd0, 6'd1, 8'd192, 1'b0},
    // R2: pedestal of 100
    '{{16'd100, 16'd100, 16'd140, 16'd300, 16'd500, 16'd300, 16'd200, 16'd100}, 8'd96, 16'd100, 6'd2, 8'd176, 1'b0},
    // R6: peak at index 0
    '{{16'd300, 16'd200, 16'd100, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0}, 8'd128, 16'd0, 6'd0, 8'd0, 1'b1},
    // R2 R5: negative samples
    '{{-16'sd50, -16'sd40, -16'sd20, 16'd30, 16'd80, 16'd60, 16'd0, -16'sd10}, 8'd128, 16'd0, 6'd3, 8'd51, 1'b0},
    // R6: nothing below threshold before the peak
    '{{16'd90, 16'd95, 16'd100, 16'd100, 16'd20, 16'd10, 16'd5, 16'd0}, 8'd128, 16'd0, 6'd0, 8'd0, 1'b1},
    // R2: tied peaks, earliest wins
    '{{16'd0, 16'd10, 16'd100, 16'd30, 16'd100, 16'd5, 16'd0, 16'd0}, 8'd128, 16'd0, 6'd1, 8'd113, 1'b0},
    // R6: peak not above zero
    '{{-16'sd5, -16'sd5, -16'sd5, -16'sd5, -16'sd5, -16'sd5, -16'sd5, -16'sd5}, 8'd128, 16'd0, 6'd0, 8'd0, 1'b1},
    // R3: fraction 255
    '{{16'd0, 16'd20, 16'd60, 16'd120, 16'd200, 16'd150, 16'd100, 16'd50}, 8'd255, 16'd0, 6'd3, 8'd252, 1'b0},
    // R3: fraction 0
    '{{-16'sd50, -16'sd40, -16'sd20, 16'd30, 16'd80, 16'd60, 16'd0, -16'sd10}, 8'd0, 16'd0, 6'd2, 8'd102, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [11:0] in_data = '0, pedestal = '0;
  logic [7:0] frac_sel = 8'd128;
  logic in_ready, out_valid, out_error;
  logic [5:0] out_index;
  logic [7:0] out_frac;
  int checks = 0, errors = 0, cyc = 0;
  logic [5:0] r_idx;
  logic [7:0] r_fr;
  logic r_err;

  always #2 clk = ~clk;

  cfd_timer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_first(in_first), .in_last(in_last),
    .frac_sel(frac_sel), .pedestal(pedestal), .out_valid(out_valid),
    .out_ready(out_ready), .out_index(out_index), .out_frac(out_frac),
    .out_error(out_error)
  );

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual %0d expected <150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input logic [11:0] d, input logic f, input logic l);
    in_data  = d;
    in_first = f;
    in_last  = l;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_first = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic get_result();
    int n = 0;
    out_ready = 1'b1;
    while (!out_valid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    chk("R7 result appears", int'(out_valid), 1);
    r_idx = out_index;
    r_fr  = out_frac;
    r_err = out_error;
    @(negedge clk);
  endtask

  task automatic send_vec(input int v, input logic first_flag);
    pedestal = VEC[v].ped[11:0];
    frac_sel = VEC[v].frac;
    for (int i = 0; i < 8; i++) push(VEC[v].s[i][11:0], (i == 0) && first_flag, i == 7);
  endtask

  task automatic check_vec(input int v, input string tag);
    chk($sformatf("%s vec %0d index", tag, v), int'(r_idx), int'(VEC[v].idx));
    chk($sformatf("%s vec %0d fraction", tag, v), int'(r_fr), int'(VEC[v].fr));
    chk($sformatf("%s vec %0d error", tag, v), int'(r_err), int'(VEC[v].err));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 out_valid in reset", int'(out_valid), 0);
    chk("R1 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 out_valid after reset", int'(out_valid), 0);
    chk("R1 in_ready after reset", int'(in_ready), 1);

    for (int v = 0; v < NV; v++) begin
      send_vec(v, 1'b1);
      get_result();
      check_vec(v, "R2/R3/R4/R5/R6");
    end

    // R7 R8: held result while a stray sample waits at the input
    out_ready = 1'b0;
    send_vec(1, 1'b1);
    while (!out_valid) @(negedge clk);
    r_idx = out_index;
    r_fr  = out_frac;
    in_data = 12'd2000; in_last = 1'b1; in_first = 1'b1; in_valid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R7 valid held", int'(out_valid), 1);
      chk("R7 index held", int'(out_index), int'(r_idx));
      chk("R7 fraction held", int'(out_frac), int'(r_fr));
      chk("R8 in_ready low while busy", int'(in_ready), 0);
    end
    in_valid = 1'b0; in_last = 1'b0; in_first = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R7 one result per window", int'(out_valid), 0);
    send_vec(1, 1'b1);
    get_result();
    check_vec(1, "R8 stray sample ignored");

    // R9: samples past depth are dropped
    frac_sel = 8'd128;
    pedestal = '0;
    for (int i = 0; i < 70; i++) begin
      logic [11:0] d;
      d = (i < 8) ? 12'd0 : (i == 9) ? 12'd200 : (i < 64) ? 12'd100 : 12'd1000;
      push(d, i == 0, i == 69);
    end
    get_result();
    chk("R9 overflow index", int'(r_idx), 8);
    chk("R9 overflow fraction", int'(r_fr), 0);
    chk("R9 overflow error", int'(r_err), 0);

    // R10: first flag restarts a partly received window
    push(12'd1500, 1'b1, 1'b0);
    push(12'd1500, 1'b0, 1'b0);
    push(12'd1500, 1'b0, 1'b0);
    send_vec(1, 1'b1);
    get_result();
    check_vec(1, "R10 restart");

    summary();
    $finish;
  end
endmodule